// File: doc/BRIEF.md
# Integer Execute Stage

This block is the execute stage of a small 32-bit load-store processor. Each input beat carries one 32-bit instruction word plus the values already read for its two source register slots. The first slot is the register named by bits 25:21. The second slot is the register named by bits 20:16. The stage decodes the instruction, builds the second operand from either the register value or the 16-bit immediate, and computes the result. It returns the result, the destination register index and a write strobe on the following clock.

Both edges of the block are valid/ready streams, with one output register between them.

- An input beat is taken on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high when the output register is empty, or when it is being drained in the same cycle (`out_ready` high).
- A result waiting with `out_ready` low keeps all output fields still until it is taken.
- A throughput of one instruction per cycle holds as long as the consumer keeps `out_ready` high.

Top module: `int_exec_stage`

## Requirements
- R1: After reset the stage presents `out_valid`=0, `out_wen`=0, `out_result`=0 and `in_ready`=1.
- R2: With opcode (bits 31:26) equal to 0, function code (bits 5:0) 0x20 gives `src_a + src_b` and 0x22 gives `src_a - src_b`, both wrapping modulo 2^32. The destination is bits 15:11.
- R3: With opcode 0, function code 0x24 gives AND, 0x25 gives OR, and 0x27 gives NOT(`src_a` OR `src_b`) of the two source values. NOR with a zero source value equals the bitwise NOT of the other source.
- R4: With opcode 0, function code 0x00 shifts `src_b` left and 0x02 shifts it right by bits 10:6 (0 to 31). Vacated bits are filled with zeros.
- R5: Opcode 0x08 adds `src_a` to the immediate (bits 15:0) sign-extended from bit 15. The destination is bits 20:16.
- R6: Opcode 0x0A yields 1 when `src_a` is less than the sign-extended immediate as signed 32-bit values, and 0 otherwise.
- R7: Opcode 0x0C ANDs and opcode 0x0D ORs `src_a` with the immediate zero-extended to 32 bits.
- R8: Opcode 0x0F yields the immediate in bits 31:16 with bits 15:0 zero.
- R9: `out_wen` is 0 whenever `out_dest` is 0.
- R10: `out_wen` is 0 for any opcode other than those listed, for an opcode-0 function code other than those listed, and for a shift whose bits 25:21 are not zero.
- R11: A beat is accepted exactly when `in_valid` and `in_ready` are high at a rising edge. Its result appears with `out_valid`=1 after that edge. `in_ready` equals NOT `out_valid` OR `out_ready`.
- R12: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_result`, `out_dest` and `out_wen` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Stage can take a beat this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Value of the first source register slot |
| src_b | input | 32 | Value of the second source register slot |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Computed result |
| out_dest | output | 5 | Destination register index |
| out_wen | output | 1 | Register write strobe |

## Verification
Directed operands are chosen to separate look-alike behaviours:
- all-ones plus one and zero minus one expose missing wrap-around;
- a negative immediate tells sign extension from zero extension, in both the add and the compare paths;
- an equal compare and a negative-against-positive compare tell signed from unsigned ordering;
- shift counts of 0 and 31 pin the shifter ends.

Dedicated patterns reach the decode rejections: a zero destination, a foreign opcode, an unknown function code, and a shift with a nonzero bits 25:21. Random legal encodings then run against random back-pressure and input bubbles. This shows that stalls hold the output and that no beat is lost or taken twice.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int XLEN = 32;
  localparam int OPW  = 6;
  localparam int FNW  = 6;
  localparam int RIW  = 5;
  localparam int IMMW = 16;
  localparam int SHW  = $clog2(XLEN);

  localparam logic [OPW-1:0] OPC_REG  = 6'h00;
  localparam logic [OPW-1:0] OPC_ADDI = 6'h08;
  localparam logic [OPW-1:0] OPC_SLTI = 6'h0A;
  localparam logic [OPW-1:0] OPC_ANDI = 6'h0C;
  localparam logic [OPW-1:0] OPC_ORI  = 6'h0D;
  localparam logic [OPW-1:0] OPC_LUI  = 6'h0F;

  localparam logic [FNW-1:0] FN_SLL = 6'h00;
  localparam logic [FNW-1:0] FN_SRL = 6'h02;
  localparam logic [FNW-1:0] FN_ADD = 6'h20;
  localparam logic [FNW-1:0] FN_SUB = 6'h22;
  localparam logic [FNW-1:0] FN_AND = 6'h24;
  localparam logic [FNW-1:0] FN_OR  = 6'h25;
  localparam logic [FNW-1:0] FN_NOR = 6'h27;

  typedef enum logic [3:0] {
    EOP_NONE,
    EOP_ADD,
    EOP_SUB,
    EOP_AND,
    EOP_OR,
    EOP_NOR,
    EOP_SLL,
    EOP_SRL,
    EOP_SLT,
    EOP_PASSB
  } exu_op_e;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] src_b,
  output exu_op_e         op,
  output logic [XLEN-1:0] opnd_b,
  output logic [SHW-1:0]  shamt,
  output logic [RIW-1:0]  dest,
  output logic            known,
  output logic            wen
);
  localparam int EXTW = XLEN - IMMW;

  logic [OPW-1:0]  f_opc;
  logic [RIW-1:0]  f_rs, f_rt, f_rd;
  logic [FNW-1:0]  f_fn;
  logic [IMMW-1:0] f_imm;
  logic [XLEN-1:0] imm_sext, imm_zext, imm_high;

  assign f_opc = instr[XLEN-1 -: OPW];
  assign f_rs  = instr[XLEN-OPW-1 -: RIW];
  assign f_rt  = instr[XLEN-OPW-RIW-1 -: RIW];
  assign f_rd  = instr[XLEN-OPW-2*RIW-1 -: RIW];
  assign shamt = instr[FNW +: SHW];
  assign f_fn  = instr[FNW-1:0];
  assign f_imm = instr[IMMW-1:0];

  assign imm_sext = {{EXTW{f_imm[IMMW-1]}}, f_imm};
  assign imm_zext = {{EXTW{1'b0}}, f_imm};
  assign imm_high = {f_imm, {EXTW{1'b0}}};

  always_comb begin
    op     = EOP_NONE;
    opnd_b = src_b;
    dest   = f_rt;
    case (f_opc)
      OPC_REG: begin
        dest = f_rd;
        case (f_fn)
          FN_ADD:  op = EOP_ADD;
          FN_SUB:  op = EOP_SUB;
          FN_AND:  op = EOP_AND;
          FN_OR:   op = EOP_OR;
          FN_NOR:  op = EOP_NOR;
          FN_SLL:  op = (f_rs == '0) ? EOP_SLL : EOP_NONE;
          FN_SRL:  op = (f_rs == '0) ? EOP_SRL : EOP_NONE;
          default: op = EOP_NONE;
        endcase
      end
      OPC_ADDI: begin op = EOP_ADD;   opnd_b = imm_sext; end
      OPC_SLTI: begin op = EOP_SLT;   opnd_b = imm_sext; end
      OPC_ANDI: begin op = EOP_AND;   opnd_b = imm_zext; end
      OPC_ORI:  begin op = EOP_OR;    opnd_b = imm_zext; end
      OPC_LUI:  begin op = EOP_PASSB; opnd_b = imm_high; end
      default:  op = EOP_NONE;
    endcase
  end

  assign known = (op != EOP_NONE);
  assign wen   = known && (dest != '0);
endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] amt,
  input  logic          left,
  output logic [W-1:0]  res
);
  logic [W-1:0] st [SW+1];

  assign st[0] = val;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign st[k+1] = amt[k] ? (left ? (st[k] << (1 << k)) : (st[k] >> (1 << k)))
                            : st[k];
  end

  assign res = st[SW];
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
(
  input  exu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [SHW-1:0]  shamt,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] sh_res;

  exu_shift #(.W(XLEN), .SW(SHW)) u_shift (
    .val  (b),
    .amt  (shamt),
    .left (op == EOP_SLL),
    .res  (sh_res)
  );

  always_comb begin
    case (op)
      EOP_ADD:   res = a + b;
      EOP_SUB:   res = a - b;
      EOP_AND:   res = a & b;
      EOP_OR:    res = a | b;
      EOP_NOR:   res = ~(a | b);
      EOP_SLL,
      EOP_SRL:   res = sh_res;
      EOP_SLT:   res = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      EOP_PASSB: res = b;
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/int_exec_stage.sv
module int_exec_stage
  import exu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic [RIW-1:0]  out_dest,
  output logic            out_wen
);
  exu_op_e         dec_op;
  logic [XLEN-1:0] dec_b;
  logic [SHW-1:0]  dec_sh;
  logic [RIW-1:0]  dec_dest;
  logic            dec_known, dec_wen;
  logic [XLEN-1:0] alu_res;
  logic            take;

  exu_decode u_dec (
    .instr  (instr),
    .src_b  (src_b),
    .op     (dec_op),
    .opnd_b (dec_b),
    .shamt  (dec_sh),
    .dest   (dec_dest),
    .known  (dec_known),
    .wen    (dec_wen)
  );

  exu_alu u_alu (
    .op    (dec_op),
    .a     (src_a),
    .b     (dec_b),
    .shamt (dec_sh),
    .res   (alu_res)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_dest   <= '0;
      out_wen    <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= alu_res;
      out_dest   <= dec_dest;
      out_wen    <= dec_wen;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                   && $stable(out_dest) && $stable(out_wen)));

  a_r9_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dest == '0) |-> !out_wen);

  a_r10_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !dec_known) |=> !out_wen);

  a_r8_lui_low: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dec_op == EOP_PASSB) |=> (out_result[IMMW-1:0] == '0));

  a_r6_slt_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dec_op == EOP_SLT) |=> (out_result[XLEN-1:1] == '0));
endmodule

// File: tb/int_exec_stage_bench.sv
module int_exec_stage_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] instr = 0, src_a = 0, src_b = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [31:0] out_result;
  logic [4:0]  out_dest;
  logic        out_wen;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  int_exec_stage u_int_exec_stage (
    .clk, .rst_n, .in_valid, .in_ready, .instr, .src_a, .src_b,
    .out_valid, .out_ready, .out_result, .out_dest, .out_wen
  );

  // reference model state
  bit          m_valid = 0;
  bit          m_hold  = 0;
  logic [31:0] m_res   = 0;
  logic [4:0]  m_dest  = 0;
  bit          m_wen   = 0;
  string       m_tag   = "R1";

  function automatic logic [31:0] rtype(int fn, int rs, int rt, int rd, int sh);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction

  function automatic logic [31:0] itype(int opc, int rs, int rt, int imm);
    return {opc[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic ref_exec(input logic [31:0] ins, input logic [31:0] a,
                          input logic [31:0] b, output logic [31:0] res,
                          output logic [4:0] dst, output bit we,
                          output string tag);
    int opc = int'(ins[31:26]);
    int fn  = int'(ins[5:0]);
    int sh  = int'(ins[10:6]);
    logic [31:0] se = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] ze = {16'h0, ins[15:0]};
    bit ok = 1;
    res = 0;
    dst = (opc == 0) ? ins[15:11] : ins[20:16];
    tag = "R10";
    if (opc == 0) begin
      if      (fn == 'h20) begin res = a + b;    tag = "R2"; end
      else if (fn == 'h22) begin res = a - b;    tag = "R2"; end
      else if (fn == 'h24) begin res = a & b;    tag = "R3"; end
      else if (fn == 'h25) begin res = a | b;    tag = "R3"; end
      else if (fn == 'h27) begin res = ~(a | b); tag = "R3"; end
      else if (fn == 'h00 && ins[25:21] == 0) begin res = b << sh; tag = "R4"; end
      else if (fn == 'h02 && ins[25:21] == 0) begin res = b >> sh; tag = "R4"; end
      else ok = 0;
    end
    else if (opc == 'h08) begin res = a + se; tag = "R5"; end
    else if (opc == 'h0A) begin res = ($signed(a) < $signed(se)) ? 1 : 0; tag = "R6"; end
    else if (opc == 'h0C) begin res = a & ze; tag = "R7"; end
    else if (opc == 'h0D) begin res = a | ze; tag = "R7"; end
    else if (opc == 'h0F) begin res = {ins[15:0], 16'h0}; tag = "R8"; end
    else ok = 0;
    we = ok && (dst != 0);
    if (ok && dst == 0) tag = "R9";
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 0;
      m_hold  <= 0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      logic [31:0] r; logic [4:0] d; bit w; string t;
      ref_exec(instr, src_a, src_b, r, d, w, t);
      m_valid <= 1; m_hold <= 0;
      m_res <= r; m_dest <= d; m_wen <= w; m_tag <= t;
    end else if (out_ready) begin
      m_valid <= 0; m_hold <= 0;
    end else begin
      m_hold <= m_valid;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (instr=%h)", tag, act, exp, instr);
    end
  endtask

  task automatic compare_now();
    string t = m_hold ? "R12" : m_tag;
    check("R11 out_valid", 32'(out_valid), 32'(m_valid));
    check("R11 in_ready", 32'(in_ready), 32'(!m_valid || out_ready));
    if (m_valid) begin
      check({t, " result"}, out_result, m_res);
      check({t, " dest"},   32'(out_dest), 32'(m_dest));
      check({t, " wen"},    32'(out_wen), 32'(m_wen));
    end
  endtask

  task automatic send(logic [31:0] ins, logic [31:0] a, logic [31:0] b, int stall);
    bit acc = 0;
    while (!acc) begin
      @(negedge clk);
      compare_now();
      in_valid  = 1;
      instr     = ins;
      src_a     = a;
      src_b     = b;
      out_ready = (($urandom % 100) >= stall);
      #1;
      acc = in_ready;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_now();
      in_valid  = 0;
      out_ready = 1;
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 out_wen", 32'(out_wen), 0);
    check("R1 out_result", out_result, 0);
    check("R1 in_ready", 32'(in_ready), 1);

    // R2 add / sub wrap
    send(rtype('h20, 1, 2, 3, 0), 32'hFFFF_FFFF, 32'h1, 0);
    send(rtype('h22, 1, 2, 4, 0), 32'h0, 32'h1, 0);
    send(rtype('h20, 1, 2, 31, 7), 32'h1234_5678, 32'h1111_1111, 0);
    // R3 logic, nor as NOT
    send(rtype('h24, 1, 2, 5, 0), 32'h0000_0DC0, 32'h0000_3C00, 0);
    send(rtype('h25, 1, 2, 6, 0), 32'h0000_0DC0, 32'h0000_3C00, 0);
    send(rtype('h27, 1, 0, 7, 0), 32'h0000_3C00, 32'h0, 0);
    // R4 shifts at extremes
    send(rtype('h00, 0, 2, 8, 0),  32'h0, 32'h8000_0001, 0);
    send(rtype('h00, 0, 2, 8, 31), 32'h0, 32'hFFFF_FFFF, 0);
    send(rtype('h02, 0, 2, 8, 31), 32'h0, 32'h8000_0000, 0);
    send(rtype('h02, 0, 2, 8, 8),  32'h0, 32'hABCD_1234, 0);
    // R5 addi negative
    send(itype('h08, 1, 9, 'hFFFF), 32'h5, 32'hDEAD_BEEF, 0);
    send(itype('h08, 1, 9, 'h7FFF), 32'h7FFF_FFFF, 32'h0, 0);
    // R6 slti signed
    send(itype('h0A, 1, 10, 15), 32'hFFFF_FFF0, 32'h0, 0);
    send(itype('h0A, 1, 10, 'hFFFF), 32'h0000_0001, 32'h0, 0);
    send(itype('h0A, 1, 10, 'hFFFE), 32'hFFFF_FFFE, 32'h0, 0);
    // R7 zero extension
    send(itype('h0C, 1, 11, 'hFF00), 32'hFFFF_FFFF, 32'h0, 0);
    send(itype('h0D, 1, 11, 'h8000), 32'h0000_0001, 32'h0, 0);
    // R8 lui
    send(itype('h0F, 0, 12, 'hAAAA), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    // R9 destination zero
    send(rtype('h20, 1, 2, 0, 0), 32'h3, 32'h4, 0);
    send(itype('h0D, 1, 0, 'h1234), 32'h0, 32'h0, 0);
    // R10 rejected encodings
    send(itype('h23, 1, 13, 'h0010), 32'h1, 32'h2, 0);
    send(rtype('h21, 1, 2, 14, 0), 32'h1, 32'h2, 0);
    send(rtype('h02, 1, 2, 15, 4), 32'h0, 32'hF0, 0);
    // R12 stalls
    for (int i = 0; i < 20; i++)
      send(itype('h08, 1, 16 + i % 8, i * 37), 32'(i), 32'h0, 70);

    // random mix with back-pressure and bubbles
    for (int i = 0; i < 400; i++) begin
      int k = $urandom % 14;
      int sel = $urandom % 8;
      logic [31:0] ins;
      int fns [8] = '{'h20, 'h22, 'h24, 'h25, 'h27, 'h00, 'h02, 'h21};
      int ops [7] = '{'h08, 'h0A, 'h0C, 'h0D, 'h0F, 'h23, 'h04};
      if (k < 7)
        ins = rtype(fns[sel], (fns[sel] < 3) ? (($urandom % 5 == 0) ? 1 : 0) : $urandom % 32,
                    $urandom % 32, $urandom % 32, $urandom % 32);
      else
        ins = itype(ops[k - 7], $urandom % 32, $urandom % 32, $urandom % 65536);
      if ($urandom % 5 == 0) idle(1);
      send(ins, $urandom, $urandom, 40);
    end
    idle(4);
    finish_run();
  end
endmodule